// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive-approximation converter. It drives a trial word to an external capacitor DAC and, on each rising clock edge of a conversion, takes one decision bit from an external comparator. The comparator is valid at the rising edge because it resolves during the low half of the clock. A single register holds both the bits already decided and the position of the bit under test. The position is the lowest set bit of the word. Every bit works out its next value from its own value, the bit above it, the OR of all bits below it, and the comparator decision. The controller has no separate one-hot sequencer.

A conversion takes ten clocks. One sample cycle follows the accepted start. Eight decision cycles follow with `busy_o` high, and then one done cycle. In the done cycle `done_o` pulses and `result_o` holds the converted code. A start that arrives in the done cycle begins the next conversion at once, so conversions can run back to back at one per ten clocks. The states are IDLE, SAMPLE, CONVERT and DONE. The transitions are:

- IDLE to SAMPLE when start is asserted.
- SAMPLE to CONVERT unconditionally.
- CONVERT to CONVERT until the eighth decision, then CONVERT to DONE.
- DONE to SAMPLE when start is asserted, otherwise DONE to IDLE.

Top module: `sar_word_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are `dac_o` = 8'h80 (only bit 7 set), `busy_o` = 0, `done_o` = 0 and `result_o` = 8'h00.
- R2: A start sampled high in IDLE or DONE moves the block to SAMPLE. In the following cycle `dac_o` = 8'h80 and `busy_o` = 0.
- R3: After SAMPLE, `busy_o` is high for exactly 8 consecutive cycles, and `cmp_i` is sampled at the rising edge that ends each of them.
- R4: In decision cycle k (k = 0..7), the bit under test is bit 7-k, the lowest set bit of `dac_o`. At the next edge that bit takes the value of `cmp_i`: it stays 1 when `cmp_i` = 1 and clears when `cmp_i` = 0.
- R5: At the same edge, the next lower bit becomes 1, which makes it the new bit under test. All bits below it stay 0.
- R6: Bits above the bit under test keep their decided values throughout the conversion.
- R7: `done_o` is high for exactly one cycle, the cycle after the eighth decision. `result_o` then equals the final word, and it changes only in a cycle where `done_o` is high.
- R8: A start asserted during SAMPLE or CONVERT has no effect on the trial sequence, on `busy_o` or on the result.
- R9: Outside CONVERT, `cmp_i` has no effect: `dac_o` and `result_o` stay unchanged in IDLE.
- R10: A start that is held high restarts from DONE with no idle cycle, so each conversion takes 10 clocks from one SAMPLE cycle to the next.
- R11: With an ideal comparator, `cmp_i` = (input code >= `dac_o`), `result_o` equals the input code for all 256 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock; decisions are taken on rising edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, accepted in IDLE or DONE |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at or above the DAC level |
| dac_o | output | 8 | Trial word driven to the DAC |
| busy_o | output | 1 | High during the eight decision cycles |
| done_o | output | 1 | One-cycle pulse marking a completed conversion |
| result_o | output | 8 | Last converted code, updated with `done_o` |

## Verification
`dac_o` is the working register itself. A wrong bit rule therefore shows up on the DAC word at the edge right after the faulty decision, and the bench compares every trial word against a bit-by-bit model of the ideal search. A fault in the decision counter instead moves the `busy_o` window or the `done_o` pulse by at least one cycle. It can also let a ninth update corrupt the settled bit 0, which is caught at the done cycle through `result_o`. Both ways of ignoring a start are checked by looking at the trial sequence and the done timing that a wrongly accepted start would disturb.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SAMPLE  = 2'd1,
        S_CONVERT = 2'd2,
        S_DONE    = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_bit_cell.sv
// Next-value rule for one bit of the trial/result word.
module sar_bit_cell (
    input  logic bit_i,    // current value of this bit
    input  logic above_i,  // value of the next more significant bit
    input  logic below_i,  // OR of every less significant bit
    input  logic cmp_i,    // comparator decision
    output logic next_o
);

    // Below set: already decided, hold.
    // Below clear and self set: bit under test, take the decision.
    // Below clear and self clear: inherit the marker from above.
    always_comb begin
        next_o = (~below_i & ~bit_i & above_i)
               | ( bit_i  & cmp_i)
               | ( below_i & bit_i);
    end

endmodule

// File: rtl/sar_word_reg.sv
module sar_word_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] word_o,
    output logic [WIDTH-1:0] word_next_o
);

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] or_below;

    assign or_below[0] = 1'b0;

    for (genvar j = 0; j < WIDTH; j++) begin : g_cell
        logic above;
        if (j == WIDTH - 1) begin : g_top
            assign above = 1'b0;
        end else begin : g_mid
            assign above = word_q[j+1];
        end
        if (j > 0) begin : g_or
            assign or_below[j] = or_below[j-1] | word_q[j-1];
        end
        sar_bit_cell u_cell (
            .bit_i   (word_q[j]),
            .above_i (above),
            .below_i (or_below[j]),
            .cmp_i   (cmp_i),
            .next_o  (word_next_o[j])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            word_q <= MSB_ONLY;
        end else if (load_i) begin
            word_q <= MSB_ONLY;
        end else if (step_i) begin
            word_q <= word_next_o;
        end
    end

    assign word_o = word_q;

    AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> $stable(word_q)); // R9
    AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (word_q == MSB_ONLY)); // R2
    AST_MARKER_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> (word_q != '0)); // R5

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_ctrl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    sar_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register and decision counter.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CONVERT) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_SAMPLE;
            S_SAMPLE:  state_d = S_CONVERT;
            S_CONVERT: if (cnt_q == LAST_STEP) state_d = S_DONE;
            S_DONE:    state_d = start_i ? S_SAMPLE : S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        last_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            S_IDLE:    load_o = start_i;
            S_SAMPLE:  ;
            S_CONVERT: begin
                step_o = 1'b1;
                busy_o = 1'b1;
                last_o = (cnt_q == LAST_STEP);
            end
            S_DONE: begin
                done_o = 1'b1;
                load_o = start_i;
            end
            default: ;
        endcase
    end

    AST_BUSY_FOLLOWS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_SAMPLE) |=> busy_o); // R3
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !last_o) |=> busy_o); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> (done_o && !busy_o)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && start_i) |=> (state_q == S_SAMPLE)); // R10

endmodule

// File: rtl/sar_word_ctrl.sv
module sar_word_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);

    logic             load;
    logic             step;
    logic             last;
    logic [WIDTH-1:0] word_next;
    logic [WIDTH-1:0] result_q;

    sar_seq_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    sar_word_reg #(.WIDTH(WIDTH)) u_word (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .step_i      (step),
        .cmp_i       (cmp_i),
        .word_o      (dac_o),
        .word_next_o (word_next)
    );

    // Capture the settled word at the final decision edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_q <= '0;
        end else if (last) begin
            result_q <= word_next;
        end
    end

    assign result_o = result_q;

    AST_RESULT_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> done_o); // R7
    AST_RESULT_MATCHES_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o == dac_o)); // R7

endmodule

// File: tb/sar_word_ctrl_tb_top.sv
module sar_word_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [W-1:0] vin;
    logic         ovr_en;
    logic         ovr_val;
    logic         cmp;
    logic [W-1:0] dac;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Ideal comparator unless overridden.
    assign cmp = ovr_en ? ovr_val : (vin >= dac);

    sar_word_ctrl #(.WIDTH(W)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .cmp_i    (cmp),
        .dac_o    (dac),
        .busy_o   (busy),
        .done_o   (done),
        .result_o (result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Checks the eight trial words of one conversion against the ideal search,
    // starting at the negedge right after the SAMPLE cycle.
    task automatic check_trials(input int code, input bit hold_start);
        int dec = 0;
        for (int j = W - 1; j >= 0; j--) begin
            @(negedge clk);
            start = hold_start;
            chk(busy == 1'b1, "R3 busy during decision", busy, 1);
            // R4/R5/R6: decided upper bits, marker at bit j, zeros below
            chk(dac == W'(dec | (1 << j)), "R4/R5/R6 trial word", dac, dec | (1 << j));
            if (code >= (dec | (1 << j))) dec = dec | (1 << j);
        end
    endtask

    task automatic convert(input int code, input bit hold_start);
        @(negedge clk);
        vin   = W'(code);
        start = 1'b1;
        @(negedge clk);                 // start taken, now SAMPLE
        start = hold_start;
        chk(dac == 8'h80, "R2 sample word", dac, 8'h80);
        chk(busy == 1'b0, "R2 busy low in sample", busy, 0);
        check_trials(code, hold_start);
        start = 1'b0;
        @(negedge clk);                 // DONE
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(busy == 1'b0, "R3 busy ends", busy, 0);
        chk(result == W'(code), hold_start ? "R8 result with stray start" : "R11 result",
            result, code);
        @(negedge clk);                 // IDLE
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        chk(result == W'(code), "R7 result held", result, code);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; start = 1'b0; vin = '0; ovr_en = 1'b0; ovr_val = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac == 8'h80, "R1 dac in reset", dac, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac == 8'h80, "R1 dac after reset", dac, 8'h80);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(result == 8'h00, "R1 result", result, 0);
    endtask

    task automatic test_idle_cmp();
        logic [W-1:0] d0 = dac;
        logic [W-1:0] r0 = result;
        ovr_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            ovr_val = i[0];
            @(negedge clk);
            chk(dac == d0, "R9 dac stable in idle", dac, d0);
            chk(result == r0, "R9 result stable in idle", result, r0);
            chk(busy == 1'b0 && done == 1'b0, "R9 no activity", {busy, done}, 0);
        end
        ovr_en = 1'b0;
    endtask

    task automatic test_back_to_back(input int c1, input int c2);
        @(negedge clk);
        vin   = W'(c1);
        start = 1'b1;
        @(negedge clk);                 // SAMPLE of first
        check_trials(c1, 1'b1);
        @(negedge clk);                 // DONE of first, start still high
        chk(done == 1'b1, "R10 first done", done, 1);
        chk(result == W'(c1), "R10 first result", result, c1);
        vin = W'(c2);
        @(negedge clk);                 // SAMPLE of second, 10 clocks after first
        chk(dac == 8'h80, "R10 restart word", dac, 8'h80);
        chk(done == 1'b0 && busy == 1'b0, "R10 restart flags", {busy, done}, 0);
        start = 1'b0;
        check_trials(c2, 1'b0);
        @(negedge clk);
        chk(done == 1'b1, "R10 second done", done, 1);
        chk(result == W'(c2), "R10 second result", result, c2);
        @(negedge clk);
        chk(done == 1'b0, "R10 returns idle", done, 0);
    endtask

    task automatic test_all_codes();
        for (int c = 0; c < 256; c++) begin
            convert(c, 1'b0);
        end
    endtask

    initial begin
        test_reset();
        test_idle_cmp();
        convert(8'hA5, 1'b0);
        test_idle_cmp();
        convert(8'h5A, 1'b1);          // R8: start held through the conversion
        test_back_to_back(8'h3C, 8'hC3);
        test_all_codes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule